// File: doc/BRIEF.md
# Streaming 3x3 Local Peak Detector

The block reads a two-dimensional array of unsigned samples in raster order, one sample per accepted cycle. The last sample of a row is followed directly by the first sample of the next row. Frames follow each other with no gap. The block writes out a stream in the same order. Each output sample is either the original value, when that value is the largest in the 3x3 neighbourhood centred on it, or zero. Zero is the smallest legal value, so it can never be taken for a peak. No flag bits are added to the data.

The datapath has several parts. A row comparator takes the largest of three consecutive samples. Two row-length delay lines feed a cross-row comparator that turns those row maxima into the 3x3 maximum. A second delay line holds each original sample until its windowed maximum is ready. An output filter then zeroes a sample when it differs from that maximum, when it is below a programmable threshold, or when its window touches the frame margin. Every stage moves only when a sample is accepted, so idle cycles between samples do not change the result. Row length, frame height and sample width are parameters.

Top module: `peak3x3_stream`

## Requirements
- R1: The pipeline advances only on a cycle with `valid_i` high. A cycle with `valid_i` low changes no state, and `valid_o` is low in the cycle that follows it. The output stream does not depend on idle cycles between samples.
- R2: Accepted samples are numbered from 0 after reset. The output for sample k is presented, with `valid_o` high, in the cycle after sample k+ROW_LEN+4 is accepted. Outputs keep the input order.
- R3: A sample whose 3x3 window has no other sample of equal or greater value, and which is not on the margin and not below the threshold, is output unchanged.
- R4: A sample that is smaller than the maximum of its 3x3 window is output as 0.
- R5: A sample that would otherwise survive is output as 0 when it is less than `thresh_i`. `thresh_i` is sampled at the clock edge that registers the output. A value equal to the threshold survives.
- R6: Outputs at row 0, row ROWS-1, column 0 or column ROW_LEN-1 of a frame are 0.
- R7: During and after reset, `valid_o` and `data_o` are 0. The first ROW_LEN+4 accepted samples after reset produce no valid output.
- R8: A sample equal to the maximum of its window survives even when neighbours hold the same value (plateaus). All such interior samples of a flat region are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample on `data_i` is accepted this cycle |
| data_i | input | DATA_W | Raster-order input sample, unsigned |
| thresh_i | input | DATA_W | Minimum value a peak must reach |
| valid_o | output | 1 | `data_o` holds a new output sample |
| data_o | output | DATA_W | Peak value or 0 |

## Verification
The in-RTL assertions check several things on every cycle. The row comparator never reports less than the newest sample it took in, and it holds its value while the stream is idle. `valid_o` appears only after an accepted sample, and any nonzero output meets the threshold in force at its edge. Some behaviours depend on the contents of whole frames, and only the bench's frame scenarios can show them. These are the keeping or zeroing of each sample against a software 3x3 reference, the exact latency in accepted samples, margin zeroing, plateau ties, and insensitivity to random gaps in the input.

// File: rtl/peak_pkg.sv
package peak_pkg;
  // pipeline depth beyond one row: row compare (3) + cross-row stage (1)
  localparam int unsigned PIPE_EXTRA = 4;
endpackage

// File: rtl/peak_pe.sv
module peak_pe #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] max_o
);
  logic [DATA_W-1:0] a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (en_i) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  assign max_o = (a_q >= b_q) ? a_q : b_q;
endmodule

// File: rtl/peak_dly.sv
module peak_dly #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] sr_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
    end else if (en_i) begin
      sr_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) sr_q[i] <= sr_q[i-1];
    end
  end

  assign q_o = sr_q[DEPTH-1];
endmodule

// File: rtl/peak_row_max.sv
module peak_row_max #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] x_i,
  output logic [DATA_W-1:0] max_o
);
  logic [DATA_W-1:0] prev_q, pair_max;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prev_q <= '0;
    else if (en_i) prev_q <= x_i;
  end

  // x_i is broadcast to both compare elements
  peak_pe #(.DATA_W(DATA_W)) u_pe_a (
    .clk_i, .rst_ni, .en_i, .a_i(prev_q), .b_i(x_i), .max_o(pair_max)
  );
  peak_pe #(.DATA_W(DATA_W)) u_pe_b (
    .clk_i, .rst_ni, .en_i, .a_i(pair_max), .b_i(x_i), .max_o(max_o)
  );

  assert_row_max_covers_newest_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> max_o >= $past(x_i));
  assert_row_hold_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(max_o));
endmodule

// File: rtl/peak_col_max.sv
module peak_col_max #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ROW_LEN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] h_i,
  output logic [DATA_W-1:0] max_o
);
  logic [DATA_W-1:0] up1, up2, cur_q, far_max;

  peak_dly #(.DATA_W(DATA_W), .DEPTH(ROW_LEN)) u_tap1 (
    .clk_i, .rst_ni, .en_i, .d_i(h_i), .q_o(up1)
  );
  peak_dly #(.DATA_W(DATA_W), .DEPTH(ROW_LEN)) u_tap2 (
    .clk_i, .rst_ni, .en_i, .d_i(up1), .q_o(up2)
  );

  // aligns the current row with the registered maximum of the two older rows
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cur_q <= '0;
    else if (en_i) cur_q <= h_i;
  end

  peak_pe #(.DATA_W(DATA_W)) u_pe_old (
    .clk_i, .rst_ni, .en_i, .a_i(up2), .b_i(up1), .max_o(far_max)
  );
  peak_pe #(.DATA_W(DATA_W)) u_pe_new (
    .clk_i, .rst_ni, .en_i, .a_i(far_max), .b_i(cur_q), .max_o(max_o)
  );
endmodule

// File: rtl/peak_filter.sv
module peak_filter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] orig_i,
  input  logic [DATA_W-1:0] win_max_i,
  input  logic [DATA_W-1:0] thresh_i,
  input  logic              margin_i,
  output logic [DATA_W-1:0] res_o
);
  logic is_peak, above;

  always_comb begin
    is_peak = (orig_i == win_max_i);
    above   = (orig_i >= thresh_i);
    res_o   = (is_peak && above && !margin_i) ? orig_i : '0;
  end
endmodule

// File: rtl/peak3x3_stream.sv
module peak3x3_stream
  import peak_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ROW_LEN = 8,
  parameter int unsigned ROWS    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] thresh_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned LAT    = ROW_LEN + PIPE_EXTRA;
  localparam int unsigned COL_W  = (ROW_LEN > 1) ? $clog2(ROW_LEN) : 1;
  localparam int unsigned ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int unsigned FILL_W = $clog2(LAT + 1);

  logic              adv;
  logic [DATA_W-1:0] row_max, win_max, orig, res;
  logic [FILL_W-1:0] fill_q;
  logic [COL_W-1:0]  col_q;
  logic [ROW_W-1:0]  row_q;
  logic              out_fire, on_margin;

  assign adv = valid_i;

  peak_row_max #(.DATA_W(DATA_W)) u_row (
    .clk_i, .rst_ni, .en_i(adv), .x_i(data_i), .max_o(row_max)
  );
  peak_col_max #(.DATA_W(DATA_W), .ROW_LEN(ROW_LEN)) u_col (
    .clk_i, .rst_ni, .en_i(adv), .h_i(row_max), .max_o(win_max)
  );
  peak_dly #(.DATA_W(DATA_W), .DEPTH(LAT)) u_orig (
    .clk_i, .rst_ni, .en_i(adv), .d_i(data_i), .q_o(orig)
  );

  assign out_fire  = adv && (fill_q == FILL_W'(LAT));
  assign on_margin = (col_q == '0) || (col_q == COL_W'(ROW_LEN - 1)) ||
                     (row_q == '0) || (row_q == ROW_W'(ROWS - 1));

  peak_filter #(.DATA_W(DATA_W)) u_filt (
    .orig_i(orig), .win_max_i(win_max), .thresh_i(thresh_i),
    .margin_i(on_margin), .res_o(res)
  );

  // output-aligned position counters
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      col_q  <= '0;
      row_q  <= '0;
    end else begin
      if (adv && fill_q != FILL_W'(LAT)) fill_q <= fill_q + 1'b1;
      if (out_fire) begin
        if (col_q == COL_W'(ROW_LEN - 1)) begin
          col_q <= '0;
          row_q <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= out_fire;
      if (out_fire) data_o <= res;
    end
  end

  assert_valid_after_input_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));
  assert_idle_no_output_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_peak_meets_thresh_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && data_o != '0) |-> data_o >= $past(thresh_i));
  assert_reset_quiet_R7: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && data_o == '0));
endmodule

// File: tb/sim_peak3x3_stream.sv
module sim_peak3x3_stream;
  localparam int DW  = 8;
  localparam int NX  = 8;
  localparam int NY  = 6;
  localparam int FS  = NX * NY;
  localparam int LAT = NX + 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] thresh_i = '0;
  logic          valid_o;
  logic [DW-1:0] data_o;

  always #2ns clk = ~clk;

  peak3x3_stream #(.DATA_W(DW), .ROW_LEN(NX), .ROWS(NY)) u0 (
    .clk_i(clk), .rst_ni, .valid_i, .data_i, .thresh_i, .valid_o, .data_o
  );

  int mem [2048];
  int n_in = 0, n_out = 0, n_chk = 0, n_fail = 0;
  int thr_used = 0;
  bit v_used = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int expect_out(input int j, input int thr, output string tag);
    int f, p, r, c, v, m;
    bit tie;
    f = j / FS; p = j % FS; r = p / NX; c = p % NX;
    v = mem[j];
    if (r == 0 || r == NY-1 || c == 0 || c == NX-1) begin tag = "R6"; return 0; end
    m = 0; tie = 0;
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++) begin
        int s;
        s = mem[f*FS + (r+dr)*NX + c + dc];
        if (s > m) m = s;
        if ((dr != 0 || dc != 0) && s == v) tie = 1;
      end
    if (v != m)  begin tag = "R4"; return 0; end
    if (v < thr) begin tag = "R5"; return 0; end
    tag = tie ? "R8" : "R3";
    return v;
  endfunction

  task automatic check_out();
    bit exp_v;
    int e;
    string tag;
    exp_v = v_used && (n_in - 1 >= LAT);
    n_chk++;
    if (valid_o !== exp_v) begin
      n_fail++;
      $display("FAIL %s valid_o after input %0d: actual %0b expected %0b",
               (n_in - 1 < LAT) ? "R7" : (v_used ? "R2" : "R1"), n_in, valid_o, exp_v);
    end
    if (valid_o === 1'b1) begin
      e = expect_out(n_out, thr_used, tag);
      n_chk++;
      if (data_o !== DW'(e)) begin
        n_fail++;
        $display("FAIL %s output %0d: actual %0d expected %0d", tag, n_out, data_o, e);
      end
      n_out++;
    end
  endtask

  task automatic step(input bit v, input int d, input int thr);
    valid_i  = v;
    data_i   = DW'(d);
    thresh_i = DW'(thr);
    @(posedge clk);
    if (v) begin mem[n_in] = d; n_in++; end
    v_used   = v;
    thr_used = thr;
    @(negedge clk);
    check_out();
  endtask

  // one frame; mode 0 random small, 1 random wide, 2 flat, 3 zeros
  task automatic frame(input int mode, input int thr, input bit gaps);
    int k = 0;
    while (k < FS) begin
      if (gaps && ($urandom % 3 == 0)) begin
        step(0, $urandom % 256, thr);   // R1 idle cycle with garbage data
      end else begin
        int d;
        case (mode)
          0: d = $urandom % 4;
          1: d = $urandom % 256;
          2: d = 5;
          default: d = 0;
        endcase
        step(1, d, thr);
        k++;
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (valid_o !== 1'b0 || data_o !== '0) begin
      n_fail++;
      $display("FAIL R7 reset state: actual valid %0b data %0d expected 0 0", valid_o, data_o);
    end
    rst_ni = 1'b1;
    frame(0, 0, 0);     // plateaus of small values (R3, R4, R8)
    frame(1, 0, 0);     // wide random values
    frame(1, 120, 0);   // threshold filtering (R5)
    frame(2, 5, 0);     // flat frame, thresh equal to value (R8, R5)
    frame(1, 0, 1);     // random gaps in the stream (R1)
    frame(0, 2, 1);
    frame(3, 0, 0);     // flush
    frame(3, 0, 0);
    n_chk++;
    if (n_out != n_in - LAT) begin
      n_fail++;
      $display("FAIL R2 output count: actual %0d expected %0d", n_out, n_in - LAT);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule